// File: doc/BRIEF.md
# Synthesiser Tuning Register Port

This block is the serial control port of a frequency synthesiser. It acts as an I2C target that runs on a fast system clock. It oversamples the SCL and SDA lines to find START, STOP and bit edges. It answers one of four addresses, and two external select pins choose which one. Write transfers load the 17-bit divider ratio and the control fields. Read transfers return a status byte that carries the power-on flag, the lock flag and the ADC code.

In a write transfer, each data byte after the address takes its role from its leading bit. A byte that starts with 0 carries ratio bits 14..8, and the byte after it carries bits 7..0. A byte that starts with 1 carries the two top ratio bits, the prescaler enable and the reference divider select, and the byte after it carries the charge pump, reference-output and port fields. These pairs can repeat as often as the controller likes within one transfer. The ratio is built up in a staging register. The divider sees the staged value only when all 17 bits have arrived, or when a STOP ends the transfer. A tuning step therefore never exposes a half-updated ratio.

Top module: `synth_i2c_regs`

## Requirements
- R1: The target acknowledges an address byte by pulling SDA low only when the byte equals {1,1,0,0,0,addr_sel_i[1],addr_sel_i[0],R/W}, MSB first. A non-matching address is not acknowledged and leaves every output unchanged.
- R2: Every data byte of an addressed write is acknowledged. sda_pull_o only asserts while SCL is low.
- R3: The first data byte after the address, and the byte after each completed pair, sets its role from bit 7. When bit 7 is 0, bits 6..0 become staged ratio bits 14..8. When bit 7 is 1, bits 6..5 become staged ratio bits 16..15, bit 4 drives presc_en_o and bits 3..0 drive ref_div_o, all at once.
- R4: The byte after a bit-7=1 byte sets cp_cur_o from bits 7..6, refout_en_o from bit 5 and refout_sel_o from bit 4. In normal mode, port_o is set from bits 3..0. The byte after a bit-7=0 byte sets staged ratio bits 7..0.
- R5: ratio_o takes the staged value in the same step in which the last of the three ratio byte kinds arrives. Repeated ratio byte pairs with no STOP leave ratio_o unchanged.
- R6: A STOP moves the staged ratio to ratio_o when at least one ratio byte kind has arrived since the last update.
- R7: A STOP in the middle of a byte discards the partial byte. The ratio and control fields keep their values.
- R8: When bit 5 of the control-pair byte is 0 and bit 4 is 1 (test mode), bits 2..0 go to test_sel_o, bit 3 updates port_o[3], and port_o[2:0] keeps its previous value. Outside test mode, test_sel_o is 0.
- R9: A read returns the status byte {por, lock_i, 0, 0, 0, adc_code_i}, MSB first. The byte is sent again each time the controller acknowledges. After a not-acknowledge, the target stops driving SDA.
- R10: Reset or por_event_i sets the power-on flag and returns the outputs to their defaults: ratio 0, prescaler off, divider select 0, charge pump 0, reference output enabled with select 1, test select 0, ports 0. A STOP that ends a read clears the power-on flag.
- R11: A repeated START resets the byte-role pairing, so the next data byte is decoded by its bit 7 again.
- R12: A STOP releases sda_pull_o on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull_o | output | 1 | 1 pulls SDA low (open drain) |
| addr_sel_i | input | 2 | Address select bits placed in the address byte |
| por_event_i | input | 1 | Supply power-on / drop event |
| lock_i | input | 1 | Phase lock flag |
| adc_code_i | input | ADC_W | ADC code returned in status |
| ratio_o | output | 17 | Active divider ratio |
| presc_en_o | output | 1 | Prescaler enable |
| ref_div_o | output | 4 | Reference divider select |
| cp_cur_o | output | 2 | Charge pump current select |
| refout_en_o | output | 1 | Reference output enable |
| refout_sel_o | output | 1 | Reference output select / test enable |
| test_sel_o | output | 3 | Test mode select (0 outside test mode) |
| port_o | output | 4 | Switching port states |

## Verification
The bench uses the default parameters: a two-stage line synchroniser, a 3-bit ADC code and the 11000 address base, with the address select pins tied to 10. The bench keeps SCL ten system clocks per phase. This leaves margin over the synchroniser latency, so that acknowledge timing, repeated START, mid-byte STOP and both byte-pair orders can all be exercised at the pins. The 3-bit ADC width puts real code values in the low status bits beside the lock and power-on flags.

// File: rtl/synth_i2c_pkg.sv
`timescale 1ns/1ps
package synth_i2c_pkg;

   localparam int RATIO_W = 17;

   typedef enum logic [2:0] {
      XS_IDLE,
      XS_ADDR,
      XS_AACK,
      XS_WDATA,
      XS_WACK,
      XS_RDATA,
      XS_RACK
   } xfer_st_e;

   typedef struct packed {
      logic       presc_en;
      logic [3:0] ref_div;
      logic [1:0] cp_cur;
      logic       refout_en;
      logic       refout_sel;
      logic [2:0] test_sel;
      logic [3:0] port;
   } ctrl_t;

   function automatic ctrl_t ctrl_default();
      ctrl_t c;
      c            = '0;
      c.refout_en  = 1'b1;
      c.refout_sel = 1'b1;
      return c;
   endfunction

endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise,
   output logic scl_fall,
   output logic sda_s,
   output logic start_det,
   output logic stop_det
);
   localparam int LINES = 2;

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_line_sync: STAGES must be at least 2");
   end

   logic [LINES-1:0] raw, synced, prev;
   assign raw = {scl_i, sda_i};

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[STAGES-2:0], raw[g]};
      end
      assign synced[g] = chain[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '1;
      else        prev <= synced;
   end

   logic scl_now, scl_was, sda_was;
   assign scl_now   = synced[1];
   assign scl_was   = prev[1];
   assign sda_s     = synced[0];
   assign sda_was   = prev[0];
   assign scl_rise  = scl_now & ~scl_was;
   assign scl_fall  = ~scl_now & scl_was;
   assign start_det = scl_now & scl_was & sda_was & ~sda_s;
   assign stop_det  = scl_now & scl_was & ~sda_was & sda_s;
endmodule

// File: rtl/i2c_target_fsm.sv
`timescale 1ns/1ps
module i2c_target_fsm
   import synth_i2c_pkg::*;
#(
   parameter logic [4:0] DEV_BASE = 5'b11000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_rise,
   input  logic       scl_fall,
   input  logic       sda_s,
   input  logic       start_det,
   input  logic       stop_det,
   input  logic [1:0] addr_sel,
   input  logic [7:0] status_i,
   output logic       sda_pull,
   output logic       byte_done,
   output logic [7:0] byte_data,
   output logic       rd_end
);
   xfer_st_e   st;
   logic [3:0] cnt;
   logic [7:0] shreg, tx;
   logic       hit, rw, rd_xfer;

   assign byte_data = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= XS_IDLE; cnt <= '0; shreg <= '0; tx <= '0;
         hit <= 1'b0; rw <= 1'b0; rd_xfer <= 1'b0;
         sda_pull <= 1'b0; byte_done <= 1'b0; rd_end <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         rd_end    <= 1'b0;
         if (stop_det) begin
            st <= XS_IDLE; sda_pull <= 1'b0;
            rd_end <= rd_xfer; rd_xfer <= 1'b0;
         end else if (start_det) begin
            st <= XS_ADDR; cnt <= '0; sda_pull <= 1'b0; rd_xfer <= 1'b0;
         end else begin
            unique case (st)
               XS_ADDR: begin
                  if (scl_rise && cnt != 4'd8) begin
                     shreg <= {shreg[6:0], sda_s};
                     cnt   <= cnt + 4'd1;
                     if (cnt == 4'd7) begin
                        hit <= (shreg[6:0] == {DEV_BASE, addr_sel});
                        rw  <= sda_s;
                     end
                  end else if (scl_fall && cnt == 4'd8) begin
                     if (hit) begin
                        sda_pull <= 1'b1;
                        rd_xfer  <= rw;
                        st       <= XS_AACK;
                     end else begin
                        st <= XS_IDLE;
                     end
                  end
               end
               XS_AACK: if (scl_fall) begin
                  cnt <= '0;
                  if (rw) begin
                     tx       <= status_i;
                     sda_pull <= ~status_i[7];
                     st       <= XS_RDATA;
                  end else begin
                     sda_pull <= 1'b0;
                     st       <= XS_WDATA;
                  end
               end
               XS_WDATA: begin
                  if (scl_rise && cnt != 4'd8) begin
                     shreg <= {shreg[6:0], sda_s};
                     cnt   <= cnt + 4'd1;
                     if (cnt == 4'd7) byte_done <= 1'b1;
                  end else if (scl_fall && cnt == 4'd8) begin
                     sda_pull <= 1'b1;
                     st       <= XS_WACK;
                  end
               end
               XS_WACK: if (scl_fall) begin
                  sda_pull <= 1'b0;
                  cnt      <= '0;
                  st       <= XS_WDATA;
               end
               XS_RDATA: if (scl_fall) begin
                  if (cnt == 4'd7) begin
                     sda_pull <= 1'b0;
                     st       <= XS_RACK;
                  end else begin
                     tx       <= {tx[6:0], 1'b0};
                     sda_pull <= ~tx[6];
                     cnt      <= cnt + 4'd1;
                  end
               end
               XS_RACK: begin
                  if (scl_rise && sda_s) begin
                     st <= XS_IDLE;
                  end else if (scl_fall) begin
                     tx       <= status_i;
                     sda_pull <= ~status_i[7];
                     cnt      <= '0;
                     st       <= XS_RDATA;
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/synth_reg_bank.sv
`timescale 1ns/1ps
module synth_reg_bank
   import synth_i2c_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               por_event,
   input  logic               byte_done,
   input  logic [7:0]         byte_data,
   input  logic               start_det,
   input  logic               stop_det,
   input  logic               rd_end,
   output logic [RATIO_W-1:0] ratio,
   output ctrl_t              ctrl,
   output logic               por_flag
);
   logic               second, pair_ctl;
   logic               got_hi, got_lo, got_top;
   logic [RATIO_W-1:0] stage, stage_n;
   logic               b2, b3, b4, b5, gh_n, gl_n, gt_n, commit;

   always_comb begin
      b2 = byte_done && !second && !byte_data[7];
      b4 = byte_done && !second &&  byte_data[7];
      b3 = byte_done &&  second && !pair_ctl;
      b5 = byte_done &&  second &&  pair_ctl;
      stage_n = stage;
      if (b2) stage_n[14:8]  = byte_data[6:0];
      if (b3) stage_n[7:0]   = byte_data;
      if (b4) stage_n[16:15] = byte_data[6:5];
      gh_n   = got_hi  | b2;
      gl_n   = got_lo  | b3;
      gt_n   = got_top | b4;
      commit = (gh_n & gl_n & gt_n) || (stop_det && (got_hi | got_lo | got_top));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ratio <= '0; stage <= '0; ctrl <= ctrl_default(); por_flag <= 1'b1;
         second <= 1'b0; pair_ctl <= 1'b0;
         got_hi <= 1'b0; got_lo <= 1'b0; got_top <= 1'b0;
      end else if (por_event) begin
         ratio <= '0; stage <= '0; ctrl <= ctrl_default(); por_flag <= 1'b1;
         second <= 1'b0; pair_ctl <= 1'b0;
         got_hi <= 1'b0; got_lo <= 1'b0; got_top <= 1'b0;
      end else begin
         stage <= stage_n;
         if (commit) begin
            ratio   <= stage_n;
            got_hi  <= 1'b0; got_lo <= 1'b0; got_top <= 1'b0;
         end else begin
            got_hi  <= gh_n; got_lo <= gl_n; got_top <= gt_n;
         end
         if (start_det || stop_det) begin
            second <= 1'b0;
         end else if (byte_done) begin
            second <= ~second;
            if (!second) pair_ctl <= byte_data[7];
         end
         if (b4) begin
            ctrl.presc_en <= byte_data[4];
            ctrl.ref_div  <= byte_data[3:0];
         end
         if (b5) begin
            ctrl.cp_cur     <= byte_data[7:6];
            ctrl.refout_en  <= byte_data[5];
            ctrl.refout_sel <= byte_data[4];
            if (!byte_data[5] && byte_data[4]) begin
               ctrl.test_sel <= byte_data[2:0];
               ctrl.port[3]  <= byte_data[3];
            end else begin
               ctrl.test_sel <= '0;
               ctrl.port     <= byte_data[3:0];
            end
         end
         if (rd_end) por_flag <= 1'b0;
      end
   end
endmodule

// File: rtl/synth_i2c_regs.sv
`timescale 1ns/1ps
module synth_i2c_regs
   import synth_i2c_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter int         ADC_W       = 3,
   parameter logic [4:0] DEV_BASE    = 5'b11000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   output logic               sda_pull_o,
   input  logic [1:0]         addr_sel_i,
   input  logic               por_event_i,
   input  logic               lock_i,
   input  logic [ADC_W-1:0]   adc_code_i,
   output logic [RATIO_W-1:0] ratio_o,
   output logic               presc_en_o,
   output logic [3:0]         ref_div_o,
   output logic [1:0]         cp_cur_o,
   output logic               refout_en_o,
   output logic               refout_sel_o,
   output logic [2:0]         test_sel_o,
   output logic [3:0]         port_o
);
   localparam int PAD_W = 6 - ADC_W;

   if (ADC_W < 1 || ADC_W > 5) begin : g_bad_adc
      $error("synth_i2c_regs: ADC_W must be 1..5");
   end

   logic       scl_rise, scl_fall, sda_s, start_det, stop_det;
   logic       byte_done, rd_end, por_flag;
   logic [7:0] byte_data, status;
   ctrl_t      ctrl;

   assign status = {por_flag, lock_i, {PAD_W{1'b0}}, adc_code_i};

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
      .start_det(start_det), .stop_det(stop_det)
   );

   i2c_target_fsm #(.DEV_BASE(DEV_BASE)) u_fsm (
      .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
      .addr_sel(addr_sel_i), .status_i(status), .sda_pull(sda_pull_o),
      .byte_done(byte_done), .byte_data(byte_data), .rd_end(rd_end)
   );

   synth_reg_bank u_bank (
      .clk(clk), .rst_n(rst_n), .por_event(por_event_i),
      .byte_done(byte_done), .byte_data(byte_data),
      .start_det(start_det), .stop_det(stop_det), .rd_end(rd_end),
      .ratio(ratio_o), .ctrl(ctrl), .por_flag(por_flag)
   );

   assign presc_en_o   = ctrl.presc_en;
   assign ref_div_o    = ctrl.ref_div;
   assign cp_cur_o     = ctrl.cp_cur;
   assign refout_en_o  = ctrl.refout_en;
   assign refout_sel_o = ctrl.refout_sel;
   assign test_sel_o   = ctrl.test_sel;
   assign port_o       = ctrl.port;
endmodule

// File: rtl/synth_i2c_checks.sv
`timescale 1ns/1ps
module synth_i2c_checks (
   input logic        clk,
   input logic        rst_n,
   input logic        scl_i,
   input logic        sda_pull_o,
   input logic        por_event_i,
   input logic [16:0] ratio_o,
   input logic [3:0]  port_o,
   input logic [2:0]  test_sel_o,
   input logic        refout_en_o,
   input logic        refout_sel_o,
   input logic        stop_det,
   input logic        byte_done,
   input logic        por_flag
);
   assert_pull_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull_o) |-> !scl_i);

   assert_stop_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_pull_o);

   assert_por_defaults_R10: assert property (@(posedge clk) disable iff (!rst_n)
      por_event_i |=> (ratio_o == 17'd0 && port_o == 4'd0 && por_flag));

   assert_ratio_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ratio_o) |-> $past(byte_done || stop_det || por_event_i));

   assert_test_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (test_sel_o != 3'd0) |-> (!refout_en_o && refout_sel_o));
endmodule

bind synth_i2c_regs synth_i2c_checks u_checks (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_pull_o(sda_pull_o),
   .por_event_i(por_event_i), .ratio_o(ratio_o), .port_o(port_o),
   .test_sel_o(test_sel_o), .refout_en_o(refout_en_o),
   .refout_sel_o(refout_sel_o), .stop_det(stop_det),
   .byte_done(byte_done), .por_flag(por_flag)
);

// File: tb/tb_synth_i2c_regs.sv
`timescale 1ns/1ps
module tb_synth_i2c_regs;
   localparam int HALF = 10;
   localparam int K_OBS = 0, K_RATIO = 1, K_CTRL = 2, K_PULL = 3;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
   logic por_event = 1'b0, lock = 1'b0;
   logic [2:0] adc = 3'd0;
   logic [1:0] asel = 2'b10;
   logic sda_pull, presc_en, refout_en, refout_sel;
   logic [16:0] ratio;
   logic [3:0] ref_div, port;
   logic [1:0] cp_cur;
   logic [2:0] test_sel;
   wire  sda_line = sda_m & ~sda_pull;

   synth_i2c_regs dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_pull_o(sda_pull), .addr_sel_i(asel), .por_event_i(por_event),
      .lock_i(lock), .adc_code_i(adc), .ratio_o(ratio), .presc_en_o(presc_en),
      .ref_div_o(ref_div), .cp_cur_o(cp_cur), .refout_en_o(refout_en),
      .refout_sel_o(refout_sel), .test_sel_o(test_sel), .port_o(port)
   );

   typedef struct { string req; int kind; logic [31:0] exp; logic [31:0] obs; } item_t;
   item_t q[$];
   int checks = 0, fails = 0;
   bit done = 1'b0;
   event chk_ev;

   task automatic tick(int n); repeat (n) @(negedge clk); endtask

   task automatic expect_item(string req, int kind, logic [31:0] exp, logic [31:0] obs = 0);
      item_t it;
      it.req = req; it.kind = kind; it.exp = exp; it.obs = obs;
      q.push_back(it);
      -> chk_ev;
   endtask

   initial forever begin
      @(chk_ev);
      while (q.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it = q.pop_front();
         case (it.kind)
            K_RATIO: act = {15'd0, ratio};
            K_CTRL:  act = {16'd0, presc_en, ref_div, cp_cur, refout_en, refout_sel, test_sel, port};
            K_PULL:  act = {31'd0, sda_pull};
            default: act = it.obs;
         endcase
         checks++;
         if (act !== it.exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
         end
      end
   end

   function automatic logic [31:0] mk_ctrl(logic pe, logic [3:0] rd, logic [1:0] cp,
                                           logic en, logic sel, logic [2:0] ts, logic [3:0] p);
      return {16'd0, pe, rd, cp, en, sel, ts, p};
   endfunction

   task automatic send_bit(logic b);
      tick(HALF/2); sda_m = b; tick(HALF/2); scl_m = 1'b1; tick(HALF); scl_m = 1'b0;
   endtask
   task automatic recv_bit(output logic b);
      tick(HALF/2); sda_m = 1'b1; tick(HALF/2); scl_m = 1'b1;
      tick(HALF/2); b = sda_line; tick(HALF/2); scl_m = 1'b0;
   endtask
   task automatic i2c_start();
      tick(HALF/2); sda_m = 1'b1; tick(HALF/2); scl_m = 1'b1;
      tick(HALF/2); sda_m = 1'b0; tick(HALF/2); scl_m = 1'b0;
   endtask
   task automatic i2c_stop();
      tick(HALF/2); sda_m = 1'b0; tick(HALF/2); scl_m = 1'b1;
      tick(HALF/2); sda_m = 1'b1; tick(HALF);
   endtask
   task automatic wr(logic [7:0] d, output logic ack);
      for (int i = 7; i >= 0; i--) send_bit(d[i]);
      recv_bit(ack);
   endtask
   task automatic rd(output logic [7:0] d, input logic give_ack);
      for (int i = 7; i >= 0; i--) recv_bit(d[i]);
      send_bit(give_ack ? 1'b0 : 1'b1);
   endtask
   task automatic wr_chk(logic [7:0] d, string req);
      logic a;
      wr(d, a);
      expect_item(req, K_OBS, 32'd0, {31'd0, a});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic a;
      logic [7:0] d0, d1;
      lock = 1'b1; adc = 3'b011;
      tick(4); rst_n = 1'b1; tick(4);
      // R10 reset defaults
      expect_item("R10 reset ratio", K_RATIO, 0);
      expect_item("R10 reset ctrl", K_CTRL, mk_ctrl(0, 4'd0, 2'd0, 1, 1, 3'd0, 4'd0));
      // R1 / R9 / R10: read after reset, POR set, then cleared by STOP
      i2c_start(); wr(8'hC5, a);
      expect_item("R1 address ack", K_OBS, 0, {31'd0, a});
      rd(d0, 1'b0);
      expect_item("R9 R10 status with POR", K_OBS, 32'hC3, {24'd0, d0});
      tick(4);
      expect_item("R9 release after nack", K_PULL, 0);
      i2c_stop();
      i2c_start(); wr(8'hC5, a); rd(d0, 1'b0); i2c_stop();
      expect_item("R10 POR cleared by read STOP", K_OBS, 32'h43, {24'd0, d0});
      // R1 wrong address
      i2c_start(); wr(8'hC0, a);
      expect_item("R1 no ack on mismatch", K_OBS, 1, {31'd0, a});
      wr(8'h55, a); wr(8'h66, a); i2c_stop();
      expect_item("R1 mismatch leaves ratio", K_RATIO, 0);
      // R2 R3 R4 R5: order 2,3,4,5
      i2c_start(); wr_chk(8'hC4, "R1 write addr ack");
      wr_chk(8'h23, "R2 data ack"); wr_chk(8'h45, "R2 data ack");
      expect_item("R5 ratio held before top bits", K_RATIO, 0);
      wr_chk(8'hD9, "R2 data ack");
      expect_item("R5 ratio commit on 17 bits", K_RATIO, 32'h12345);
      expect_item("R3 control from top byte", K_CTRL, mk_ctrl(1, 4'd9, 2'd0, 1, 1, 3'd0, 4'd0));
      wr_chk(8'h6A, "R2 data ack");
      expect_item("R4 control pair byte", K_CTRL, mk_ctrl(1, 4'd9, 2'd1, 1, 0, 3'd0, 4'b1010));
      i2c_stop(); tick(2);
      expect_item("R12 released after STOP", K_PULL, 0);
      // R5 R6: repeated 2,3 pairs, then STOP
      i2c_start(); wr(8'hC4, a);
      wr(8'h11, a); wr(8'h22, a); wr(8'h33, a); wr(8'h44, a);
      expect_item("R5 pairs without STOP no change", K_RATIO, 32'h12345);
      i2c_stop(); tick(2);
      expect_item("R6 STOP commits staged", K_RATIO, 32'h13344);
      // R3 R5: order 4,5,2,3
      i2c_start(); wr(8'hC4, a);
      wr(8'hA3, a);
      expect_item("R5 top byte alone holds", K_RATIO, 32'h13344);
      wr(8'h8F, a); wr(8'h05, a); wr(8'h06, a);
      expect_item("R5 commit order 4,5,2,3", K_RATIO, 32'h08506);
      expect_item("R3 R4 control after 4,5", K_CTRL, mk_ctrl(0, 4'd3, 2'd2, 0, 0, 3'd0, 4'b1111));
      i2c_stop();
      // R7: partial byte then STOP
      i2c_start(); wr(8'hC4, a);
      send_bit(0); send_bit(1); send_bit(1); send_bit(1); send_bit(1);
      i2c_stop(); tick(2);
      expect_item("R7 partial ratio kept", K_RATIO, 32'h08506);
      expect_item("R7 partial ctrl kept", K_CTRL, mk_ctrl(0, 4'd3, 2'd2, 0, 0, 3'd0, 4'b1111));
      // R8 test mode
      i2c_start(); wr(8'hC4, a);
      wr(8'hA3, a); wr(8'h1E, a);
      expect_item("R8 test mode keeps P2..P0", K_CTRL, mk_ctrl(0, 4'd3, 2'd0, 0, 1, 3'd6, 4'b1111));
      wr(8'hA3, a); wr(8'h20, a);
      expect_item("R8 normal mode clears test", K_CTRL, mk_ctrl(0, 4'd3, 2'd0, 1, 0, 3'd0, 4'b0000));
      i2c_stop();
      // R11 repeated START resets pairing
      i2c_start(); wr(8'hC4, a); wr(8'hC0, a);
      i2c_start(); wr(8'hC4, a); wr(8'h12, a); wr(8'h34, a);
      expect_item("R11 ratio after repeated START", K_RATIO, 32'h11234);
      expect_item("R11 ports untouched", K_CTRL, mk_ctrl(0, 4'd0, 2'd0, 1, 0, 3'd0, 4'b0000));
      i2c_stop();
      // R9 repeat on ack
      lock = 1'b0; adc = 3'b101;
      i2c_start(); wr(8'hC5, a); rd(d0, 1'b1); rd(d1, 1'b0);
      expect_item("R9 first status", K_OBS, 32'h05, {24'd0, d0});
      expect_item("R9 repeated status", K_OBS, 32'h05, {24'd0, d1});
      tick(4);
      expect_item("R9 released after nack", K_PULL, 0);
      i2c_stop();
      // R10 power-on event
      por_event = 1'b1; tick(1); por_event = 1'b0; tick(3);
      expect_item("R10 por ratio", K_RATIO, 0);
      expect_item("R10 por ctrl", K_CTRL, mk_ctrl(0, 4'd0, 2'd0, 1, 1, 3'd0, 4'd0));
      i2c_start(); wr(8'hC5, a); rd(d0, 1'b0); i2c_stop();
      expect_item("R10 POR flag after event", K_OBS, 32'h85, {24'd0, d0});
      tick(4);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule